// File: doc/BRIEF.md
# Multi-Source Level Interrupt Aggregator

This block merges a set of peripheral event sources into a single maskable interrupt request. Each source owns a pending flag that a one-cycle event pulse sets, and a mask bit that software controls. The request bit is not a latch. It is true in every cycle where at least one source is both pending and unmasked, and false otherwise. A request that disappears before the processor takes it is lost.

Software reaches the block through a small register port with three registers. The pending register can be read, and a bit is cleared by writing 0 to it. The mask register can be read and written. The control register holds the request bit and a 3-bit priority level. Writing 0 to the request bit does not clear any source. It only suppresses the request for five clock cycles, after which the request again follows the pending sources.

The processor-facing output is registered. It asserts when the request is set and the programmed level is strictly above the processor's current priority. A level of 0 therefore never interrupts. An acknowledge input exists, but it changes neither the pending flags nor the request.

Top module: `eia_irq_merge`

## Requirements
- R1: `req_o` is 1 exactly when some source has both its pending bit and its mask bit set, and no suppression window is running. A change to the pending or mask state shows on `req_o` in the cycle after the edge that made it.
- R2: The request is not held. If the last enabled pending source is cleared or unmasked, `req_o` drops to 0 after that edge and stays 0 until a source qualifies again.
- R3: Writing the control register (address 2) with bit 0 = 0 holds `req_o` at 0 for exactly 5 cycles after the write edge. After that, `req_o` follows the masked pending state again. A further such write inside the window restarts the 5-cycle count.
- R4: Writing the control register with bit 0 = 1 has no effect on `req_o`.
- R5: A pulse on `ack_i` clears neither pending bits nor `req_o`.
- R6: A 1 in `evt_i[i]` sets pending bit i at the next edge. Writing the pending register (address 0) clears every bit where the write data holds 0 and leaves bits with 1 unchanged. When an event and a clear reach the same bit in the same cycle, the event wins.
- R7: `irq_o` is registered. It is 1 in the cycle after an edge at which `req_o` was 1 and the level field was strictly greater than `ipl_i`.
- R8: A read returns data on `reg_rdata_o` after the edge that samples `reg_rd_i`, and that data is held until the next read. Address 0 reads the pending bits, address 1 reads the mask bits, address 2 reads {level in bits 3:1, `req_o` in bit 0}, and address 3 reads 0. Control-register writes load the level from bits 3:1.
- R9: After reset, the pending bits, mask bits and level are 0, and `req_o`, `irq_o` and `reg_rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_SRC | One-cycle event pulses, one per source |
| ack_i | input | 1 | Interrupt acknowledge pulse from the processor |
| ipl_i | input | LVL_W | Current processor priority level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| req_o | output | 1 | Live interrupt request bit |
| irq_o | output | 1 | Registered interrupt to the processor |

## Verification
The properties assume that event lines carry pulses and that at most one register access is made per cycle to addresses 0 to 3. Under these conditions, a set pending bit can only fall through a write to address 0. The stimulus keeps to this: directed phases perform one read or one write per cycle, and the random phase draws a single operation per cycle, together with arbitrary event pulses and priority values. A behavioural model in the bench predicts `req_o`, `irq_o` and `reg_rdata_o` on every cycle, including overlapping suppression windows and cases where an event and a clear hit the same bit.

// File: rtl/eia_pkg.sv
package eia_pkg;
  localparam int REG_AW       = 2;
  localparam int CTRL_REQ_BIT = 0;
  localparam int CTRL_LVL_LSB = 1;

  typedef enum logic [REG_AW-1:0] {
    RA_PEND  = 2'd0,
    RA_MASK  = 2'd1,
    RA_CTRL  = 2'd2,
    RA_SPARE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/eia_src_bank.sv
module eia_src_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] clr_keep_i,
  input  logic             mask_we_i,
  input  logic [N_SRC-1:0] mask_data_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] live_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic pend_q;
    logic mask_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q <= 1'b0;
      end else if (evt_i[i]) begin
        pend_q <= 1'b1;
      end else if (clr_we_i && !clr_keep_i[i]) begin
        pend_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q <= 1'b0;
      end else if (mask_we_i) begin
        mask_q <= mask_data_i[i];
      end
    end

    assign pend_o[i] = pend_q;
    assign mask_o[i] = mask_q;
    assign live_o[i] = pend_q & mask_q;
  end
endmodule

// File: rtl/eia_hold_timer.sv
module eia_hold_timer #(
  parameter int HOLD_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CNT_INIT;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/eia_prio_gate.sv
module eia_prio_gate #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] ipl_i,
  output logic             irq_o
);
  logic above;
  logic irq_q;

  assign above = (lvl_i != '0) && (lvl_i > ipl_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= req_i && above;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/eia_irq_merge.sv
module eia_irq_merge
  import eia_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int LVL_W    = 3,
  parameter int DATA_W   = 8,
  parameter int HOLD_CYC = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              ack_i,
  input  logic [LVL_W-1:0]  ipl_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              req_o,
  output logic              irq_o
);
  localparam int LVL_MSB = CTRL_LVL_LSB + LVL_W - 1;

  reg_addr_e         addr_e;
  logic              wr_pend, wr_mask, wr_ctrl, hold_load, hold_active;
  logic [N_SRC-1:0]  pend_w, mask_w, live_w;
  logic [LVL_W-1:0]  lvl_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              unused_ack;

  assign unused_ack = ack_i;
  assign addr_e     = reg_addr_e'(reg_addr_i);
  assign wr_pend    = reg_wr_i && (addr_e == RA_PEND);
  assign wr_mask    = reg_wr_i && (addr_e == RA_MASK);
  assign wr_ctrl    = reg_wr_i && (addr_e == RA_CTRL);
  assign hold_load  = wr_ctrl && !reg_wdata_i[CTRL_REQ_BIT];

  eia_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .evt_i       (evt_i),
    .clr_we_i    (wr_pend),
    .clr_keep_i  (reg_wdata_i[N_SRC-1:0]),
    .mask_we_i   (wr_mask),
    .mask_data_i (reg_wdata_i[N_SRC-1:0]),
    .pend_o      (pend_w),
    .mask_o      (mask_w),
    .live_o      (live_w)
  );

  eia_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .load_i   (hold_load),
    .active_o (hold_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
    end else if (wr_ctrl) begin
      lvl_q <= reg_wdata_i[LVL_MSB:CTRL_LVL_LSB];
    end
  end

  assign req_o = (|live_w) && !hold_active;

  eia_prio_gate #(.LVL_W(LVL_W)) u_gate (
    .clk   (clk),
    .rst   (rst),
    .req_i (req_o),
    .lvl_i (lvl_q),
    .ipl_i (ipl_i),
    .irq_o (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (addr_e)
      RA_PEND: rd_mux[N_SRC-1:0] = pend_w;
      RA_MASK: rd_mux[N_SRC-1:0] = mask_w;
      RA_CTRL: begin
        rd_mux[CTRL_REQ_BIT]          = req_o;
        rd_mux[LVL_MSB:CTRL_LVL_LSB] = lvl_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd_i) begin
      rdata_q <= rd_mux;
    end
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/eia_irq_merge_chk.sv
module eia_irq_merge_chk #(
  parameter int N_SRC  = 8,
  parameter int LVL_W  = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SRC-1:0]  evt_i,
  input logic [LVL_W-1:0]  ipl_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [1:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              req_o,
  input logic              irq_o,
  input logic [N_SRC-1:0]  pend_w,
  input logic [N_SRC-1:0]  mask_w,
  input logic [LVL_W-1:0]  lvl_q
);
  // R1: a request implies a qualifying source
  p_req_has_src_r1: assert property (@(posedge clk) disable iff (rst)
    req_o |-> ((pend_w & mask_w) != '0));

  // R3: a zero written to the request bit suppresses it next cycle
  p_hold_low_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_addr_i == 2'd2 && !reg_wdata_i[0]) |=> !req_o);

  // R4: writing one never raises the request on its own
  p_write_one_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_addr_i == 2'd2 && reg_wdata_i[0] && !req_o &&
     ((pend_w & mask_w) == '0) && (evt_i == '0)) |=> !req_o);

  // R5: pending bits only fall through a clear write
  p_pend_keep_r5: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_i && reg_addr_i == 2'd0) |=> ((pend_w & $past(pend_w)) == $past(pend_w)));

  // R6: an event always lands, even against a clear
  p_evt_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((pend_w & $past(evt_i)) == $past(evt_i)));

  // R7: the interrupt needs the request and a level above the priority
  p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(req_o) && ($past(lvl_q) > $past(ipl_i))));

  // R8: read data changes only after a read
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_i |=> $stable(reg_rdata_o));
endmodule

bind eia_irq_merge eia_irq_merge_chk #(
  .N_SRC(N_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .ipl_i(ipl_i),
  .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .req_o(req_o), .irq_o(irq_o),
  .pend_w(pend_w), .mask_w(mask_w), .lvl_q(lvl_q)
);

// File: tb/tb_eia_irq_merge.sv
module tb_eia_irq_merge;
  localparam int N  = 8;
  localparam int LW = 3;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  evt = '0;
  logic          ack = 1'b0;
  logic [LW-1:0] ipl = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          req, irq;

  int checks = 0;
  int errors = 0;
  string cur = "R9";
  bit started = 0;

  always #10 clk = ~clk;

  eia_irq_merge dut (
    .clk(clk), .rst(rst), .evt_i(evt), .ack_i(ack), .ipl_i(ipl),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .req_o(req), .irq_o(irq)
  );

  // behavioural reference
  logic [N-1:0]  m_pend, m_mask;
  logic [LW-1:0] m_lvl;
  int            m_hold;
  logic          m_irq;
  logic [DW-1:0] m_rd;

  function automatic logic m_req();
    return ((m_pend & m_mask) != '0) && (m_hold == 0);
  endfunction

  always @(posedge clk) begin
    logic          r;
    logic [DW-1:0] nrd;
    if (rst) begin
      m_pend = '0; m_mask = '0; m_lvl = '0; m_hold = 0; m_irq = 0; m_rd = '0;
    end else begin
      r = m_req();
      nrd = m_rd;
      if (rd) begin
        case (addr)
          2'd0: nrd = m_pend;
          2'd1: nrd = m_mask;
          2'd2: nrd = {4'b0, m_lvl, r};
          default: nrd = '0;
        endcase
      end
      m_irq = r && (m_lvl > ipl);
      if (wr && addr == 2'd0) m_pend = m_pend & wdata;
      m_pend = m_pend | evt;
      if (wr && addr == 2'd1) m_mask = wdata;
      if (wr && addr == 2'd2) begin
        m_lvl = wdata[3:1];
        if (!wdata[0]) m_hold = 5;
        else if (m_hold > 0) m_hold--;
      end else if (m_hold > 0) m_hold--;
      m_rd = nrd;
    end
    started = 1;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk({cur, " req"}, 32'(req), 32'(m_req()));
      chk({cur, " irq"}, 32'(irq), 32'(m_irq));
      chk({cur, " rdata"}, 32'(rdata), 32'(m_rd));
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    evt = '0; wr = 0; rd = 0; ack = 0;
  endtask

  task automatic wreg(logic [1:0] a, logic [DW-1:0] d);
    wr = 1; addr = a; wdata = d; tick();
  endtask

  task automatic rreg(logic [1:0] a);
    rd = 1; addr = a; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    cur = "R9";
    chk("R9 req", 32'(req), 0);
    chk("R9 irq", 32'(irq), 0);
    chk("R9 rdata", 32'(rdata), 0);
    rreg(2'd0); chk("R9 pend", 32'(rdata), 0);
    rreg(2'd2); chk("R9 ctrl", 32'(rdata), 0);

    // R6 set and clear of pending bits
    cur = "R6";
    evt = 8'h05; tick();
    rreg(2'd0); chk("R6 set", 32'(rdata), 32'h05);
    wreg(2'd0, 8'hFE); rreg(2'd0); chk("R6 clr", 32'(rdata), 32'h04);
    evt = 8'h04; wreg(2'd0, 8'hFB); rreg(2'd0); chk("R6 evt wins", 32'(rdata), 32'h04);
    wreg(2'd0, 8'hFF); rreg(2'd0); chk("R6 ones kept", 32'(rdata), 32'h04);

    // R1 masking
    cur = "R1";
    chk("R1 unmasked none", 32'(req), 0);
    wreg(2'd1, 8'h04); chk("R1 req on", 32'(req), 1);
    wreg(2'd1, 8'h08); chk("R1 other mask", 32'(req), 0);
    rreg(2'd1); chk("R1 mask read", 32'(rdata), 32'h08);

    // R2 request not retained
    cur = "R2";
    wreg(2'd1, 8'h04); chk("R2 up", 32'(req), 1);
    wreg(2'd0, 8'hFB); chk("R2 dropped", 32'(req), 0);
    tick(); tick(); chk("R2 lost", 32'(req), 0);

    // R7 priority gate
    cur = "R7";
    wreg(2'd1, 8'h01);
    wreg(2'd2, 8'h07);          // level 3, request bit 1
    ipl = 3'd2;
    evt = 8'h01; tick();
    chk("R7 req", 32'(req), 1);
    tick(); chk("R7 irq above", 32'(irq), 1);
    ipl = 3'd3; tick(); chk("R7 equal blocks", 32'(irq), 0);
    ipl = 3'd0; wreg(2'd2, 8'h01); tick(); chk("R7 level zero", 32'(irq), 0);
    wreg(2'd2, 8'h0F); tick(); chk("R7 level seven", 32'(irq), 1);

    // R5 acknowledge has no effect
    cur = "R5";
    ack = 1; tick(); ack = 1; tick();
    chk("R5 req kept", 32'(req), 1);
    rreg(2'd0); chk("R5 pend kept", 32'(rdata), 32'h01);

    // R3 five-cycle suppression
    cur = "R3";
    wreg(2'd2, 8'h0E);
    for (int k = 0; k < 4; k++) begin
      chk("R3 held", 32'(req), 0); tick();
    end
    chk("R3 held last", 32'(req), 0);
    tick(); chk("R3 back", 32'(req), 1);
    wreg(2'd2, 8'h0E); tick(); tick();
    wreg(2'd2, 8'h0E);          // restart in window
    for (int k = 0; k < 4; k++) begin
      chk("R3 reload held", 32'(req), 0); tick();
    end
    chk("R3 reload last", 32'(req), 0);
    tick(); chk("R3 reload back", 32'(req), 1);
    wreg(2'd2, 8'h0E); wreg(2'd0, 8'h00);
    repeat (6) tick(); chk("R3 no source", 32'(req), 0);

    // R4 writing one is ignored
    cur = "R4";
    wreg(2'd2, 8'h0F); chk("R4 no raise", 32'(req), 0);
    evt = 8'h01; tick(); wreg(2'd2, 8'h0F); chk("R4 stays", 32'(req), 1);

    // R8 read data held and layout
    cur = "R8";
    rreg(2'd2); chk("R8 ctrl", 32'(rdata), 32'h0F);
    tick(); tick(); chk("R8 held", 32'(rdata), 32'h0F);
    rreg(2'd3); chk("R8 spare", 32'(rdata), 0);

    // mixed random traffic, compared by the model each cycle
    cur = "R1";
    for (int k = 0; k < 2000; k++) begin
      int op;
      op = $urandom_range(0, 9);
      evt = ($urandom_range(0, 3) == 0) ? 8'($urandom) : '0;
      ipl = 3'($urandom);
      ack = 1'($urandom);
      addr = 2'($urandom);
      wdata = 8'($urandom);
      if (op < 3) wr = 1;
      else if (op < 6) rd = 1;
      tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule